// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block collects a set of asynchronous external lines, grouped into banks of 32, and turns the edges on them into latched pending flags, maskable interrupt levels and single-cycle event pulses. Each line is brought into the clock domain through a two-stage synchroniser. A change between the synchronised value and its one-cycle-old copy is a rising or falling edge. An edge only counts when that line's trigger-enable bit for that direction is set. A counted edge sets a pending bit that stays set until software writes a one to it.

Pending bits reach the interrupt outputs only through a per-line interrupt mask. Each bank also has a level output toward the parent interrupt controller. This output stays high for as long as any unmasked pending bit remains in that bank. A second, independent mask turns counted edges into one-cycle event pulses. A build-time option gives each bank separate rising-side and falling-side pending registers. Software reads the pending view as the OR of the two, and one acknowledge clears the bit in both.

A plain synchronous register port provides access. Each bank takes eight word slots. The bank number sits in the upper address bits and a 3-bit register offset in the low bits.

Top module: `xint_ctrl`

## Requirements
- R1: After reset, every register reads zero in every bank: interrupt mask, event mask, both trigger enables and all pending registers. `irq_line`, `irq_bank` and `evt_pulse` are all low.
- R2: Line L maps to bank L/32 and bit L%32. With its rising-trigger bit set, a 0-to-1 change on the line sets its pending bit. With its falling-trigger bit set, a 1-to-0 change sets it. With both bits set, either change sets it. The pending bit is visible a few cycles after the input changes.
- R3: An edge whose direction is not enabled for that line sets no pending bit, in its own bank or in any other bank.
- R4: Writing a word to the pending register (offset 4) clears each bit written as 1. Bits written as 0 keep their value.
- R5: When a counted edge on a line and a write-one-to-clear of that same line's pending bit land in the same clock cycle, the pending bit ends up set.
- R6: Counted edges set pending bits whatever the interrupt mask holds. `irq_line[L]` is high exactly when line L is pending and its interrupt mask bit is 1. Mask bit 0 means masked.
- R7: `irq_bank[b]` is an active-high level. It stays high while at least one unmasked pending bit remains in bank b, and it drops only once all of them are cleared or masked.
- R8: A counted edge on a line whose event mask bit is 1 gives exactly one one-cycle pulse on `evt_pulse[L]`. The pulse appears whatever the interrupt mask holds. An event mask of 0, or an edge whose direction is not enabled, gives no pulse.
- R9: With `SPLIT_FALL_PEND=1`, a counted rising edge sets the bit at offset 5 and a counted falling edge sets the bit at offset 6. Offset 4 reads their OR. A one written to offset 4 clears the bit in both registers, while a one written to offset 5 or 6 clears only that register. With `SPLIT_FALL_PEND=0`, offset 5 holds all pending bits and offset 6 reads zero.
- R10: The register offsets within a bank are: 0 interrupt mask, 1 event mask, 2 rising-trigger enable, 3 falling-trigger enable. Each of these reads back the last word written to it. `rdata` shows the register selected by `addr` one clock after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_BANKS*BANK_W | Asynchronous external lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | {bank index, 3-bit register offset} |
| wdata | input | BANK_W | Write data |
| rdata | output | BANK_W | Registered read data for `addr` |
| irq_line | output | NUM_BANKS*BANK_W | Per-line unmasked pending level |
| irq_bank | output | NUM_BANKS | Per-bank interrupt level toward the parent controller |
| evt_pulse | output | NUM_BANKS*BANK_W | Per-line one-cycle event pulses |

## Verification
The bench sweeps lines at both bank boundaries and in both banks through all four trigger-enable combinations and both edge directions. This catches a wrong bank/bit split, a swapped trigger register, and an edge that leaks into the other bank. An edge is made to coincide with a clear of the same bit. A design that lets the clear win loses an interrupt, and the bench reads that bit back as zero. The bank level is checked while masked bits are still pending and after an unmasked bit is cleared while another unmasked bit remains. A design that ORs in masked bits, or that drops the level after the first clear, is caught here. A split-pending copy runs alongside on the same stimulus. A design that clears only one side on acknowledge, or that reports the wrong side, reads back different values at offsets 4, 5 and 6.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned REG_OFS_W = 3;

  typedef enum logic [REG_OFS_W-1:0] {
    RG_IMASK  = 3'd0,
    RG_EMASK  = 3'd1,
    RG_RISE   = 3'd2,
    RG_FALL   = 3'd3,
    RG_PEND   = 3'd4,
    RG_PEND_R = 3'd5,
    RG_PEND_F = 3'd6
  } xint_reg_e;
endpackage

// File: rtl/xint_sync.sv
// Two-flop synchroniser and edge detector, one slice per line.
module xint_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise_det,
  output logic [WIDTH-1:0] fall_det
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= din[i];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise_det[i] = sync_q & ~prev_q;
      assign fall_det[i] = ~sync_q & prev_q;
    end
  endgenerate
endmodule

// File: rtl/xint_bank.sv
// Configuration, pending state and outputs for one bank of lines.
module xint_bank
  import xint_pkg::*;
#(
  parameter int unsigned BANK_W          = 32,
  parameter bit          SPLIT_FALL_PEND = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_sel,
  input  logic [REG_OFS_W-1:0] wr_ofs,
  input  logic [BANK_W-1:0]    wdata,
  input  logic [BANK_W-1:0]    rise_det,
  input  logic [BANK_W-1:0]    fall_det,
  output logic [BANK_W-1:0]    imask,
  output logic [BANK_W-1:0]    emask,
  output logic [BANK_W-1:0]    rise_en,
  output logic [BANK_W-1:0]    fall_en,
  output logic [BANK_W-1:0]    pend_r,
  output logic [BANK_W-1:0]    pend_f,
  output logic [BANK_W-1:0]    irq_line,
  output logic                 irq_any,
  output logic [BANK_W-1:0]    evt
);
  logic [BANK_W-1:0] hit_r, hit_f, hit_any;
  logic [BANK_W-1:0] set_r, clr_r, pend_eff;

  assign hit_r   = rise_det & rise_en;
  assign hit_f   = fall_det & fall_en;
  assign hit_any = hit_r | hit_f;

  assign clr_r = (wr_sel && (wr_ofs == RG_PEND || wr_ofs == RG_PEND_R))
                 ? wdata : '0;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      imask   <= '0;
      emask   <= '0;
      rise_en <= '0;
      fall_en <= '0;
    end else if (wr_sel) begin
      case (wr_ofs)
        RG_IMASK: imask   <= wdata;
        RG_EMASK: emask   <= wdata;
        RG_RISE:  rise_en <= wdata;
        RG_FALL:  fall_en <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (SPLIT_FALL_PEND) begin : g_split
      logic [BANK_W-1:0] clr_f;
      assign set_r = hit_r;
      assign clr_f = (wr_sel && (wr_ofs == RG_PEND || wr_ofs == RG_PEND_F))
                     ? wdata : '0;
      always_ff @(posedge clk) begin
        if (rst) pend_f <= '0;
        else     pend_f <= (pend_f & ~clr_f) | hit_f;
      end
    end else begin : g_single
      assign set_r  = hit_any;
      assign pend_f = '0;
    end
  endgenerate

  // Set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend_r <= '0;
    else     pend_r <= (pend_r & ~clr_r) | set_r;
  end

  assign pend_eff = pend_r | pend_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line <= '0;
      irq_any  <= 1'b0;
      evt      <= '0;
    end else begin
      irq_line <= pend_eff & imask;
      irq_any  <= |(pend_eff & imask);
      evt      <= hit_any & emask;
    end
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned NUM_BANKS       = 2,
  parameter int unsigned BANK_W          = 32,
  parameter bit          SPLIT_FALL_PEND = 1'b0,
  parameter int unsigned BANK_IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int unsigned ADDR_W          = BANK_IDX_W + REG_OFS_W,
  parameter int unsigned NUM_LINES       = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    wdata,
  output logic [BANK_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] irq_line,
  output logic [NUM_BANKS-1:0] irq_bank,
  output logic [NUM_LINES-1:0] evt_pulse
);
  logic [NUM_LINES-1:0] rise_det, fall_det;
  logic [NUM_LINES-1:0] pend_all, imask_all, emask_all, trig_all;

  logic [BANK_W-1:0] imask_a  [NUM_BANKS];
  logic [BANK_W-1:0] emask_a  [NUM_BANKS];
  logic [BANK_W-1:0] rise_a   [NUM_BANKS];
  logic [BANK_W-1:0] fall_a   [NUM_BANKS];
  logic [BANK_W-1:0] pend_r_a [NUM_BANKS];
  logic [BANK_W-1:0] pend_f_a [NUM_BANKS];

  logic [BANK_IDX_W-1:0] acc_bank;
  logic [REG_OFS_W-1:0]  acc_ofs;
  assign acc_bank = addr[ADDR_W-1:REG_OFS_W];
  assign acc_ofs  = addr[REG_OFS_W-1:0];

  xint_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (line_in),
    .rise_det (rise_det),
    .fall_det (fall_det)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = wr_en && (acc_bank == BANK_IDX_W'(b));

      xint_bank #(.BANK_W(BANK_W), .SPLIT_FALL_PEND(SPLIT_FALL_PEND)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (sel),
        .wr_ofs   (acc_ofs),
        .wdata    (wdata),
        .rise_det (rise_det[b*BANK_W +: BANK_W]),
        .fall_det (fall_det[b*BANK_W +: BANK_W]),
        .imask    (imask_a[b]),
        .emask    (emask_a[b]),
        .rise_en  (rise_a[b]),
        .fall_en  (fall_a[b]),
        .pend_r   (pend_r_a[b]),
        .pend_f   (pend_f_a[b]),
        .irq_line (irq_line[b*BANK_W +: BANK_W]),
        .irq_any  (irq_bank[b]),
        .evt      (evt_pulse[b*BANK_W +: BANK_W])
      );

      assign pend_all [b*BANK_W +: BANK_W] = pend_r_a[b] | pend_f_a[b];
      assign imask_all[b*BANK_W +: BANK_W] = imask_a[b];
      assign emask_all[b*BANK_W +: BANK_W] = emask_a[b];
      assign trig_all [b*BANK_W +: BANK_W] = rise_a[b] | fall_a[b];
    end
  endgenerate

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (32'(acc_bank) < NUM_BANKS) begin
        case (acc_ofs)
          RG_IMASK:  rdata <= imask_a[acc_bank];
          RG_EMASK:  rdata <= emask_a[acc_bank];
          RG_RISE:   rdata <= rise_a[acc_bank];
          RG_FALL:   rdata <= fall_a[acc_bank];
          RG_PEND:   rdata <= pend_r_a[acc_bank] | pend_f_a[acc_bank];
          RG_PEND_R: rdata <= pend_r_a[acc_bank];
          RG_PEND_F: rdata <= pend_f_a[acc_bank];
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_LINES-1:0] pend_all,
  input logic [NUM_LINES-1:0] imask_all,
  input logic [NUM_LINES-1:0] emask_all,
  input logic [NUM_LINES-1:0] trig_all,
  input logic [NUM_BANKS-1:0] irq_bank,
  input logic [NUM_LINES-1:0] evt_pulse
);
  logic pend_wr;
  assign pend_wr = wr_en && (addr[2:0] == 3'd4 || addr[2:0] == 3'd5 || addr[2:0] == 3'd6);

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !pend_wr |=> ((pend_all & $past(pend_all)) == $past(pend_all))); // R4

  AST_PEND_NEEDS_TRIG: assert property (@(posedge clk) disable iff (rst)
    ((pend_all & ~$past(pend_all) & ~$past(trig_all)) == '0)); // R3

  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((pend_all & imask_all) == '0) |=> (irq_bank == '0)); // R7

  AST_EVT_NEEDS_EMASK: assert property (@(posedge clk) disable iff (rst)
    ((evt_pulse & ~$past(emask_all)) == '0)); // R8
endmodule

bind xint_ctrl xint_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .pend_all  (pend_all),
  .imask_all (imask_all),
  .emask_all (emask_all),
  .trig_all  (trig_all),
  .irq_bank  (irq_bank),
  .evt_pulse (evt_pulse)
);

// File: tb/xint_ctrl_test.sv
`timescale 1ns/1ps
module xint_ctrl_test;
  localparam int NB = 2;
  localparam int W  = 32;
  localparam int NL = NB * W;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] line_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, rdata_s;
  logic [NL-1:0] irq_line, irq_line_s, evt, evt_s;
  logic [NB-1:0] irq_bank, irq_bank_s;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xint_ctrl #(.NUM_BANKS(NB), .BANK_W(W), .SPLIT_FALL_PEND(1'b0)) uut (
    .clk(clk), .rst(rst), .line_in(line_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_line(irq_line), .irq_bank(irq_bank),
    .evt_pulse(evt));

  xint_ctrl #(.NUM_BANKS(NB), .BANK_W(W), .SPLIT_FALL_PEND(1'b1)) uut_split (
    .clk(clk), .rst(rst), .line_in(line_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_s), .irq_line(irq_line_s), .irq_bank(irq_bank_s),
    .evt_pulse(evt_s));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] v, output logic [W-1:0] vs);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    v = rdata; vs = rdata_s;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(4, '1); wr(8 + 4, '1);
  endtask

  initial begin
    logic [W-1:0] v, vs;
    int lines [7] = '{0, 1, 5, 31, 32, 33, 63};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_bank", 64'(irq_bank), 0);
    chk("R1 irq_line", irq_line, 0);
    chk("R1 evt", evt | evt_s, 0);
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < 7; o++) begin
        rd(b * 8 + o, v, vs);
        chk("R1 reg", {v, vs}, 0);
      end

    // R10: config readback on bank 1
    wr(8 + 0, 32'hA5A5_0F0F);
    wr(8 + 1, 32'h1234_5678);
    wr(8 + 2, 32'h0000_FFFF);
    wr(8 + 3, 32'hF0F0_0000);
    rd(8 + 0, v, vs); chk("R10 imask", 64'(v), 64'hA5A5_0F0F);
    rd(8 + 1, v, vs); chk("R10 emask", 64'(v), 64'h1234_5678);
    rd(8 + 2, v, vs); chk("R10 rise", 64'(v), 64'h0000_FFFF);
    rd(8 + 3, v, vs); chk("R10 fall", 64'(v), 64'hF0F0_0000);
    rd(0, v, vs);     chk("R10 bank0 untouched", 64'(v), 0);
    for (int o = 0; o < 4; o++) wr(8 + o, '0);

    // R2 R3 R9: sweep lines x trigger modes x edge direction
    for (int li = 0; li < 7; li++) begin
      for (int m = 0; m < 4; m++) begin
        int L = lines[li];
        int b = L / 32;
        logic [W-1:0] bitm = W'(1) << (L % 32);
        logic [W-1:0] er = m[0] ? bitm : '0;
        logic [W-1:0] ef = m[1] ? bitm : '0;
        wr(b * 8 + 2, er);
        wr(b * 8 + 3, ef);
        @(negedge clk) line_in[L] = 1'b1;
        settle();
        rd(b * 8 + 4, v, vs);
        chk("R2 R3 rise pend", {v, vs}, {er, er});
        rd(b * 8 + 5, v, vs);
        chk("R9 rise side", {v, vs}, {er, er});
        rd(b * 8 + 6, v, vs);
        chk("R9 fall side after rise", {v, vs}, 0);
        rd((1 - b) * 8 + 4, v, vs);
        chk("R3 other bank", {v, vs}, 0);
        clear_all();
        @(negedge clk) line_in[L] = 1'b0;
        settle();
        rd(b * 8 + 4, v, vs);
        chk("R2 R3 fall pend", {v, vs}, {ef, ef});
        rd(b * 8 + 5, v, vs);
        chk("R9 rise side after fall", {v, vs}, {ef, W'(0)});
        rd(b * 8 + 6, v, vs);
        chk("R9 fall side", {v, vs}, {W'(0), ef});
        clear_all();
      end
    end
    wr(2, '0); wr(3, '0); wr(10, '0); wr(11, '0);

    // R4: write-one-to-clear
    wr(2, 32'hF);
    @(negedge clk) line_in[3:0] = 4'hF;
    settle();
    rd(4, v, vs); chk("R4 set", {v, vs}, {32'hF, 32'hF});
    wr(4, 32'h5);
    rd(4, v, vs); chk("R4 ones clear", {v, vs}, {32'hA, 32'hA});
    wr(4, 32'h0);
    rd(4, v, vs); chk("R4 zeros keep", {v, vs}, {32'hA, 32'hA});

    // R6 R7: masking and bank level
    settle();
    chk("R6 masked irq_bank", 64'(irq_bank), 0);
    chk("R6 masked irq_line", irq_line, 0);
    wr(0, 32'h2); settle();
    chk("R6 unmasked irq_line", irq_line, 64'h2);
    chk("R6 unmasked irq_bank", 64'({irq_bank, irq_bank_s}), 64'b0101);
    wr(0, 32'hA);
    wr(4, 32'h2); settle();
    chk("R7 level held", 64'(irq_bank), 64'b01);
    chk("R7 line view", irq_line, 64'h8);
    wr(4, 32'h8); settle();
    chk("R7 level drops", 64'({irq_bank, irq_bank_s}), 0);
    wr(0, '0); wr(2, '0);
    @(negedge clk) line_in[3:0] = 4'h0;
    settle();
    rd(4, v, vs); chk("R3 falls ignored", {v, vs}, 0);

    // R8: event pulses on line 40 (bank 1 bit 8)
    wr(8 + 1, 32'h100);
    wr(8 + 2, 32'h100);
    begin
      int cnt = 0, tot = 0;
      @(negedge clk) line_in[40] = 1'b1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        cnt += int'(evt[40]);
        tot += $countones(evt) + $countones(evt_s);
      end
      chk("R8 one pulse", 64'(cnt), 1);
      chk("R8 only that line", 64'(tot), 2);
    end
    rd(8 + 4, v, vs); chk("R6 pend with mask clear", {v, vs}, {32'h100, 32'h100});
    begin
      int tot = 0;
      @(negedge clk) line_in[40] = 1'b0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        tot += $countones(evt) + $countones(evt_s);
      end
      chk("R8 untriggered edge no pulse", 64'(tot), 0);
    end
    wr(8 + 1, '0);
    begin
      int tot = 0;
      @(negedge clk) line_in[40] = 1'b1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        tot += $countones(evt) + $countones(evt_s);
      end
      chk("R8 emask clear no pulse", 64'(tot), 0);
    end
    wr(8 + 2, '0);
    @(negedge clk) line_in[40] = 1'b0;
    settle();
    clear_all();

    // R5: edge beats same-cycle clear (line 4)
    wr(2, 32'h10); wr(3, 32'h10);
    @(negedge clk) line_in[4] = 1'b1;
    settle();
    rd(4, v, vs); chk("R5 armed", {v, vs}, {32'h10, 32'h10});
    @(negedge clk) line_in[4] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(4); wdata = 32'h10;
    @(negedge clk);
    wr_en = 1'b0;
    settle();
    rd(4, v, vs); chk("R5 edge wins", {v, vs}, {32'h10, 32'h10});
    rd(6, v, vs); chk("R5 R9 falling side kept", {v, vs}, {W'(0), 32'h10});
    clear_all();

    // R9: split acknowledge semantics
    @(negedge clk) line_in[4] = 1'b1;
    settle();
    @(negedge clk) line_in[4] = 1'b0;
    settle();
    rd(5, v, vs); chk("R9 both sides R", 64'(vs), 64'h10);
    rd(6, v, vs); chk("R9 both sides F", 64'(vs), 64'h10);
    wr(5, 32'h10);
    rd(4, v, vs); chk("R9 rise-only clear", {v, vs}, {W'(0), 32'h10});
    rd(6, v, vs); chk("R9 fall kept", 64'(vs), 64'h10);
    wr(4, 32'h10);
    rd(4, v, vs); chk("R9 ack clears both", {v, vs}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule